// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block decides, for every branch seen at fetch, whether the branch will be taken. It keeps no target addresses at all, only direction state, which leaves room for a large pattern table of 2-bit saturating counters. The first level of the scheme is a global register of recent conditional outcomes. The second level is the counter table, indexed by the low branch-address bits XOR the global history. The index therefore separates the behaviour of each branch and also follows branches whose outcomes move together.

A lookup presents a fetch address and a flag for conditional or unconditional. The block answers in the same cycle with a direction and with the history value it used. That history value is carried down the pipeline and returned with the resolve. At resolve the counter chosen by that history is trained. On a misprediction the global history is rebuilt from the snapshot. Unconditional branches are always reported taken and leave both the table and the history alone.

Top module: `twolevel_dir_pred`

## Requirements
- R1: After reset every counter holds 1 (weakly not-taken) and the global history is zero, so a conditional lookup at any address predicts not-taken and reports history 0.
- R2: A counter value of 2 or 3 predicts taken and 0 or 1 predicts not-taken (the prediction is counter bit 1).
- R3: The counter used for a conditional lookup is the entry at index lkAddr[12:0] XOR the current global history (13 bits, 8192 entries).
- R4: A resolve increments the entry at index rsAddr[12:0] XOR rsHist when rsTaken is 1 and decrements it when rsTaken is 0. The count saturates at 3 and at 0.
- R5: An unconditional lookup (lkValid=1, lkCond=0) reports predTaken=1. It neither changes the global history nor reads the table.
- R6: A conditional lookup without a simultaneous mispredicted resolve shifts its own prediction into the history at bit 0. Older bits move up one place and bit 12 is dropped.
- R7: A resolve with rsMispred=1 loads the history with {rsHist[11:0], rsTaken} on the next edge. This takes priority over a conditional lookup in the same cycle.
- R8: When a lookup and a resolve address the same entry in one cycle, the lookup sees the counter value from before that resolve.
- R9: predHist always shows the global history held before the current cycle's update. predTaken is 0 when lkValid is 0.
- R10: A resolve with rsMispred=0 does not change the global history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lkValid | input | 1 | A branch lookup is presented this cycle |
| lkCond | input | 1 | 1 for a conditional branch, 0 for an unconditional one |
| lkAddr | input | ADDR_W | Fetch address of the branch being looked up |
| rsValid | input | 1 | A conditional branch resolves this cycle |
| rsAddr | input | ADDR_W | Address of the resolving branch |
| rsTaken | input | 1 | Actual outcome of the resolving branch |
| rsHist | input | IDX_W | History snapshot captured when that branch was looked up |
| rsMispred | input | 1 | The resolving branch was mispredicted |
| predTaken | output | 1 | Predicted direction for the current lookup |
| predHist | output | IDX_W | Global history used by the current lookup |

## Verification
The checker watches the history register on every cycle. It confirms that a conditional lookup shifts in its own prediction, that a mispredict rebuilds the history from the snapshot and the outcome even while a lookup is present, and that the history stays put otherwise. It also confirms that unconditional lookups always come back taken and that an idle port reports not-taken. Counter contents cannot be seen at the ports, so training, saturation at both ends, XOR indexing and the old-value read on a same-entry collision are shown only by the bench's scripted sequences. Each sequence steers the history to a known value and then looks up the entry it just trained.

// File: rtl/dirpred_pkg.sv
package dirpred_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic forceTaken;   // unconditional lookup: answer taken, no table read
    logic readCtr;      // conditional lookup: use counter bit 1
    logic shiftHist;    // shift prediction into history
    logic restoreHist;  // reload history from resolve snapshot
    logic writeCtr;     // train the resolve entry
  } ctrlStrobes_t;

  localparam int CTR_W   = 2;
  localparam logic [CTR_W-1:0] CTR_INIT = 2'd1;
  localparam logic [CTR_W-1:0] CTR_MAX  = 2'd3;

  function automatic logic [CTR_W-1:0] satStep(input logic [CTR_W-1:0] cur, input logic up);
    if (up)  return (cur == CTR_MAX) ? cur : cur + 1'b1;
    else     return (cur == '0)      ? cur : cur - 1'b1;
  endfunction

endpackage

// File: rtl/dirpred_ctrl.sv
module dirpred_ctrl
  import dirpred_pkg::*;
(
  input  logic         lkValid,
  input  logic         lkCond,
  input  logic         rsValid,
  input  logic         rsMispred,
  output ctrlStrobes_t strb
);

  logic recover;

  always_comb begin
    recover          = rsValid & rsMispred;
    strb.forceTaken  = lkValid & ~lkCond;
    strb.readCtr     = lkValid & lkCond;
    strb.restoreHist = recover;
    // a recovering resolve squashes the speculative shift of this cycle
    strb.shiftHist   = lkValid & lkCond & ~recover;
    strb.writeCtr    = rsValid;
  end

endmodule

// File: rtl/dirpred_datapath.sv
module dirpred_datapath
  import dirpred_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 13,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic [ADDR_W-1:0] rsAddr,
  input  logic              rsTaken,
  input  logic [IDX_W-1:0]  rsHist,
  output logic              predTaken,
  output logic [IDX_W-1:0]  predHist
);

  localparam int SLOTS  = 1 << SLOT_W;
  localparam int WORD_W = SLOTS * CTR_W;
  localparam int ROW_W  = IDX_W - SLOT_W;
  localparam int ROWS   = 1 << ROW_W;

  // counters packed SLOTS per row to keep the row count low
  logic [WORD_W-1:0] patTable [ROWS];
  logic [IDX_W-1:0]  globHist;

  logic [IDX_W-1:0]  lkIdx, rsIdx;
  logic [WORD_W-1:0] lkRow, rsRow;
  logic [CTR_W-1:0]  lkCtr, rsCtr, rsNext;

  assign lkIdx = lkAddr[IDX_W-1:0] ^ globHist;
  assign rsIdx = rsAddr[IDX_W-1:0] ^ rsHist;
  assign lkRow = patTable[lkIdx[IDX_W-1:SLOT_W]];
  assign rsRow = patTable[rsIdx[IDX_W-1:SLOT_W]];

  always_comb begin
    lkCtr = lkRow[lkIdx[SLOT_W-1:0]*CTR_W +: CTR_W];
    rsCtr = rsRow[rsIdx[SLOT_W-1:0]*CTR_W +: CTR_W];
    rsNext = satStep(rsCtr, rsTaken);
  end

  assign predTaken = strb.forceTaken | (strb.readCtr & lkCtr[CTR_W-1]);
  assign predHist  = globHist;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) patTable[r] <= {SLOTS{CTR_INIT}};
    end else if (strb.writeCtr) begin
      patTable[rsIdx[IDX_W-1:SLOT_W]][rsIdx[SLOT_W-1:0]*CTR_W +: CTR_W] <= rsNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 globHist <= '0;
    else if (strb.restoreHist) globHist <= {rsHist[IDX_W-2:0], rsTaken};
    else if (strb.shiftHist)   globHist <= {globHist[IDX_W-2:0], predTaken};
  end

endmodule

// File: rtl/twolevel_dir_pred.sv
module twolevel_dir_pred
  import dirpred_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic              lkCond,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              rsValid,
  input  logic [ADDR_W-1:0] rsAddr,
  input  logic              rsTaken,
  input  logic [IDX_W-1:0]  rsHist,
  input  logic              rsMispred,
  output logic              predTaken,
  output logic [IDX_W-1:0]  predHist
);

  ctrlStrobes_t strb;

  dirpred_ctrl u_ctrl (
    .lkValid   (lkValid),
    .lkCond    (lkCond),
    .rsValid   (rsValid),
    .rsMispred (rsMispred),
    .strb      (strb)
  );

  dirpred_datapath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .lkAddr    (lkAddr),
    .rsAddr    (rsAddr),
    .rsTaken   (rsTaken),
    .rsHist    (rsHist),
    .predTaken (predTaken),
    .predHist  (predHist)
  );

endmodule

// File: rtl/dirpred_chk.sv
module dirpred_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              lkValid,
  input logic              lkCond,
  input logic [ADDR_W-1:0] lkAddr,
  input logic              rsValid,
  input logic [ADDR_W-1:0] rsAddr,
  input logic              rsTaken,
  input logic [IDX_W-1:0]  rsHist,
  input logic              rsMispred,
  input logic              predTaken,
  input logic [IDX_W-1:0]  predHist
);

  // R5
  uncond_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && !lkCond) |-> predTaken);

  // R9
  idle_not_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |-> !predTaken);

  // R6
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkCond && !(rsValid && rsMispred)) |=>
      predHist == {$past(predHist[IDX_W-2:0]), $past(predTaken)});

  // R7
  hist_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rsValid && rsMispred) |=> predHist == {$past(rsHist[IDX_W-2:0]), $past(rsTaken)});

  // R10
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(lkValid && lkCond) && !(rsValid && rsMispred)) |=> $stable(predHist));

endmodule

bind twolevel_dir_pred dirpred_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_twolevel_dir_pred.sv
module tb_twolevel_dir_pred;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 13;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              lkValid = 1'b0, lkCond = 1'b0;
  logic [ADDR_W-1:0] lkAddr = '0, rsAddr = '0;
  logic              rsValid = 1'b0, rsTaken = 1'b0, rsMispred = 1'b0;
  logic [IDX_W-1:0]  rsHist = '0;
  logic              predTaken;
  logic [IDX_W-1:0]  predHist;

  int checks = 0;
  int errors = 0;

  twolevel_dir_pred #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        lk;
    logic        cond;
    logic [15:0] lAddr;
    logic        rs;
    logic [15:0] rAddr;
    logic        rTk;
    logic [12:0] rHist;
    logic        rMis;
    logic        expTk;
    logic [12:0] expHist;
  } vec_t;

  localparam int NVEC = 17;
  // lk cond lAddr  rs rAddr rTk rHist  rMis expTk expHist
  localparam vec_t VEC [NVEC] = '{
    '{1,1,16'h0005, 0,16'h0000,0,13'h0000,0, 0,13'h0000}, // idx 5 ctr1 -> not taken
    '{0,0,16'h0000, 1,16'h0005,1,13'h0000,1, 0,13'h0000}, // train idx5 ->2, hist<=1
    '{1,1,16'h0004, 0,16'h0000,0,13'h0000,0, 1,13'h0001}, // 4^1=5 ctr2 -> taken
    '{1,0,16'h0123, 0,16'h0000,0,13'h0000,0, 1,13'h0003}, // uncond taken, hist kept
    '{1,1,16'h0006, 1,16'h0005,0,13'h0000,0, 1,13'h0003}, // 6^3=5 reads old 2 while dec to 1
    '{1,1,16'h0002, 0,16'h0000,0,13'h0000,0, 0,13'h0007}, // 2^7=5 ctr1
    '{0,0,16'h0000, 1,16'h0005,0,13'h0000,0, 0,13'h000E}, // dec ->0
    '{0,0,16'h0000, 1,16'h0005,0,13'h0000,0, 0,13'h000E}, // dec at 0 stays 0
    '{1,1,16'h000B, 0,16'h0000,0,13'h0000,0, 0,13'h000E}, // 11^14=5 ctr0
    '{1,1,16'h0000, 1,16'h0005,1,13'h1FFF,1, 0,13'h001C}, // restore beats shift
    '{1,1,16'h0005, 0,16'h0000,0,13'h0000,0, 1,13'h1FFF}, // 5^1FFF=1FFA ctr2
    '{0,0,16'h0000, 1,16'h0005,1,13'h1FFF,0, 0,13'h1FFF}, // ->3
    '{0,0,16'h0000, 1,16'h0005,1,13'h1FFF,0, 0,13'h1FFF}, // 3 stays 3
    '{0,0,16'h0000, 1,16'h0005,1,13'h1FFF,0, 0,13'h1FFF}, // 3 stays 3
    '{0,0,16'h0000, 1,16'h0005,0,13'h1FFF,0, 0,13'h1FFF}, // ->2
    '{1,1,16'h0005, 0,16'h0000,0,13'h0000,0, 1,13'h1FFF}, // 2 -> taken
    '{0,0,16'h0000, 0,16'h0000,0,13'h0000,0, 0,13'h1FFF}  // idle
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic l, input logic c, input logic [15:0] la,
                       input logic r, input logic [15:0] ra, input logic rt,
                       input logic [12:0] rh, input logic rm);
    lkValid = l; lkCond = c; lkAddr = {16'h0, la};
    rsValid = r; rsAddr = {16'h0, ra}; rsTaken = rt; rsHist = rh; rsMispred = rm;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, several addresses, history stays 0 (predictions 0)
    foreach (VEC[i]) begin end
    for (int a = 0; a < 3; a++) begin
      @(negedge clk);
      drive(1, 1, (a == 0) ? 16'h0000 : (a == 1) ? 16'h1FFF : 16'hABCD, 0, 0, 0, 0, 0);
      #1;
      check("R1 reset taken", predTaken, 0);
      check("R1 reset hist", predHist, 0);
    end

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      drive(VEC[v].lk, VEC[v].cond, VEC[v].lAddr, VEC[v].rs, VEC[v].rAddr,
            VEC[v].rTk, VEC[v].rHist, VEC[v].rMis);
      #1;
      check($sformatf("R2 R3 R4 R8 direction vec %0d", v), predTaken, VEC[v].expTk);
      check($sformatf("R6 R7 R10 history vec %0d", v), predHist, VEC[v].expHist);
    end

    // R9: idle port reports not-taken even where the counter says taken
    @(negedge clk);
    drive(0, 1, 16'h0005, 0, 0, 0, 0, 0);
    #1;
    check("R9 idle", predTaken, 0);

    // R5: an unconditional lookup leaves history unchanged next cycle
    @(negedge clk);
    drive(1, 0, 16'h0777, 0, 0, 0, 0, 0);
    #1;
    check("R5 uncond taken", predTaken, 1);
    @(negedge clk);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    #1;
    check("R5 uncond hist", predHist, 13'h1FFF);

    // R1: reset mid-run restores counters and history
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    drive(1, 1, 16'h1FFA, 0, 0, 0, 0, 0);
    #1;
    check("R1 rereset hist", predHist, 0);
    check("R1 rereset taken", predTaken, 0);

    @(negedge clk);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule